// File: doc/BRIEF.md
# I2C Two-Channel Select Controller

This block is a bus target on a two-wire serial bus that holds one small control register. Three bits of the register pick which of two downstream bus segments is joined to the upstream bus, or join neither. The block also watches two active-low interrupt lines from the downstream segments. It merges them into one active-low output, and it reports their live state whenever the register is read.

The serial clock and data lines are sampled by the system clock through synchronisers. Start and stop conditions are found from the synchronised levels. The block drives the data line only through an open-drain pull-down enable. A host writes the register with one address byte (direction bit 0) and one or more data bytes. The new selection stays pending and reaches the switch controls only on the stop condition that ends the write. A host reads with the direction bit set to 1. It may keep acknowledging to read the status byte again and again, and each byte reflects the interrupt lines as they stand when that byte is loaded.

Top module: `i2c_chan_mux`

## Requirements
- R1: The block answers only an address byte whose upper seven bits are 1110 followed by the strap inputs `strap_i[2:0]`, most significant first; the eighth bit is the direction (0 write, 1 read). Any other address gets no acknowledge, and the block ignores the rest of that transaction.
- R2: After a matching address byte, and after every data byte of a write, the block holds `sda_pull_o` high for the whole high period of the ninth clock.
- R3: In a write, only bits 2..0 of a data byte are kept and bits 7..3 are dropped. The switch outputs keep their previous values until the stop condition, and after it they follow the kept bits.
- R4: Register decode: bit 2 = 0 turns `chan_en_o` off and `chan_sel_o` low. Value 1x0 gives `chan_en_o`=1 and `chan_sel_o`=0, and value 1x1 gives `chan_en_o`=1 and `chan_sel_o`=1. Bit 1 has no effect on the outputs but is stored and read back.
- R5: A read returns, most significant bit first, the byte {0, 0, INT1, INT0, 0, reg[2:0]}. INTn is the inverse of the synchronised `irq_n_i[n]`, and reg is the register in effect, not any pending write.
- R6: While the host acknowledges, the block sends a fresh status byte on each following group of eight clocks. It never pulls the data line during the host's acknowledge slot. After a not-acknowledge it releases the line until the next start or stop.
- R7: A write may carry any number of data bytes. Each one is acknowledged, and the last one before the stop is the one that takes effect.
- R8: A start condition anywhere, including in the middle of a byte, drops any pending write and returns the block to address matching.
- R9: `irq_n_o` is low whenever either `irq_n_i` line is low, and high when both are high.
- R10: Reset (synchronous, active high) clears the register to 000, so both channels are off. After reset `sda_pull_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus) |
| strap_i | input | 3 | Low three address bits from strap pins |
| irq_n_i | input | 2 | Active-low interrupt lines of channels 1 and 0 |
| sda_pull_o | output | 1 | When high, pull the data line low |
| irq_n_o | output | 1 | Combined active-low interrupt |
| chan_en_o | output | 1 | Connect one channel when high |
| chan_sel_o | output | 1 | Channel number to connect (0 or 1) |

## Verification
The bench writes data bytes with the upper five bits set. A design that kept those bits would report a wrong register value in the following read. It holds the bus open for many cycles between the last data acknowledge and the stop, so a design that applied the selection early would show an early change on the switch outputs. It breaks a write byte with a start after three bits, then reads back. A design that kept the pending value, or did not return to address matching, would change channels or fail to acknowledge. The bench also changes an interrupt line during the host acknowledge of a multi-byte read and expects the next byte to carry the new level, and then clocks the bus after a not-acknowledge to catch any stray pull-down.

// File: rtl/mux_pkg.sv
package mux_pkg;
  localparam int BYTE_BITS = 8;
  localparam int REG_BITS  = 3;
  localparam int NUM_IRQ   = 2;
  localparam logic [3:0] DEV_HI = 4'b1110;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_AACK,
    PH_WBYTE,
    PH_WACK,
    PH_RBYTE,
    PH_RACK,
    PH_HOLD
  } phase_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_q,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_sh;
  logic [STAGES-1:0] sda_sh;
  logic scl_p;
  logic sda_p;
  logic scl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh[0] <= scl_i;
      sda_sh[0] <= sda_i;
      for (int k = 1; k < STAGES; k++) begin
        scl_sh[k] <= scl_sh[k-1];
        sda_sh[k] <= sda_sh[k-1];
      end
      scl_p <= scl_q;
      sda_p <= sda_q;
    end
  end

  assign scl_q    = scl_sh[STAGES-1];
  assign sda_q    = sda_sh[STAGES-1];
  assign scl_rise = scl_q & ~scl_p;
  assign scl_fall = ~scl_q & scl_p;
  assign start_ev = scl_q & scl_p & sda_p & ~sda_q;
  assign stop_ev  = scl_q & scl_p & ~sda_p & sda_q;
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import mux_pkg::*;
#(
  parameter logic [3:0] ADDR_HI = DEV_HI
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scl_rise,
  input  logic                 scl_fall,
  input  logic                 sda_q,
  input  logic                 start_ev,
  input  logic                 stop_ev,
  input  logic [2:0]           strap_i,
  input  logic [BYTE_BITS-1:0] tx_byte,
  output logic                 sda_pull_o,
  output logic                 wr_stb,
  output logic [REG_BITS-1:0]  wr_data
);
  localparam int CW = $clog2(BYTE_BITS + 1);
  localparam logic [CW-1:0] FULL = CW'(BYTE_BITS);

  phase_t               st;
  logic [CW-1:0]        cnt;
  logic [BYTE_BITS-1:0] sh;
  logic                 host_ack;
  logic                 addr_hit;

  assign addr_hit = (sh[BYTE_BITS-1:1] == {ADDR_HI, strap_i});

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= PH_IDLE;
      cnt        <= '0;
      sh         <= '0;
      host_ack   <= 1'b0;
      sda_pull_o <= 1'b0;
      wr_stb     <= 1'b0;
      wr_data    <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start_ev) begin
        st         <= PH_ADDR;
        cnt        <= '0;
        sda_pull_o <= 1'b0;
      end else if (stop_ev) begin
        st         <= PH_IDLE;
        sda_pull_o <= 1'b0;
      end else begin
        unique case (st)
          PH_ADDR, PH_WBYTE: begin
            if (scl_rise) begin
              sh  <= {sh[BYTE_BITS-2:0], sda_q};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              cnt <= '0;
              if (st == PH_WBYTE) begin
                wr_stb     <= 1'b1;
                wr_data    <= sh[REG_BITS-1:0];
                sda_pull_o <= 1'b1;
                st         <= PH_WACK;
              end else if (addr_hit) begin
                sda_pull_o <= 1'b1;
                st         <= sh[0] ? PH_AACK : PH_AACK;
                host_ack   <= sh[0];
              end else begin
                st <= PH_IDLE;
              end
            end
          end
          PH_AACK: begin
            if (scl_fall) begin
              if (host_ack) begin
                sh         <= tx_byte;
                sda_pull_o <= ~tx_byte[BYTE_BITS-1];
                cnt        <= CW'(1);
                st         <= PH_RBYTE;
              end else begin
                sda_pull_o <= 1'b0;
                cnt        <= '0;
                st         <= PH_WBYTE;
              end
            end
          end
          PH_WACK: begin
            if (scl_fall) begin
              sda_pull_o <= 1'b0;
              cnt        <= '0;
              st         <= PH_WBYTE;
            end
          end
          PH_RBYTE: begin
            if (scl_fall) begin
              if (cnt == FULL) begin
                sda_pull_o <= 1'b0;
                st         <= PH_RACK;
              end else begin
                sda_pull_o <= ~sh[BYTE_BITS-2];
                sh         <= {sh[BYTE_BITS-2:0], 1'b0};
                cnt        <= cnt + 1'b1;
              end
            end
          end
          PH_RACK: begin
            if (scl_rise) begin
              host_ack <= ~sda_q;
            end else if (scl_fall) begin
              if (host_ack) begin
                sh         <= tx_byte;
                sda_pull_o <= ~tx_byte[BYTE_BITS-1];
                cnt        <= CW'(1);
                st         <= PH_RBYTE;
              end else begin
                st <= PH_HOLD;
              end
            end
          end
          default: begin
            sda_pull_o <= 1'b0;
          end
        endcase
      end
    end
  end

  // R2
  ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((st == PH_AACK) || (st == PH_WACK)) && scl_rise |-> sda_pull_o);

  // R6
  nack_release_chk: assert property (@(posedge clk) disable iff (rst)
    (st == PH_HOLD) |-> !sda_pull_o);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st == PH_IDLE) |-> !sda_pull_o);
endmodule

// File: rtl/chan_reg.sv
module chan_reg
  import mux_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_stb,
  input  logic [REG_BITS-1:0]  wr_data,
  input  logic                 start_ev,
  input  logic                 stop_ev,
  input  logic [NUM_IRQ-1:0]   irq_n_i,
  output logic                 chan_en_o,
  output logic                 chan_sel_o,
  output logic                 irq_n_o,
  output logic [BYTE_BITS-1:0] status_o
);
  logic [REG_BITS-1:0] pend_q;
  logic [REG_BITS-1:0] act_q;
  logic                pend_v;
  logic [NUM_IRQ-1:0]  irq_s;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) begin
        sh <= '1;
      end else begin
        sh[0] <= irq_n_i[g];
        for (int k = 1; k < STAGES; k++) sh[k] <= sh[k-1];
      end
    end
    assign irq_s[g] = sh[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      pend_v <= 1'b0;
      act_q  <= '0;
    end else if (start_ev) begin
      pend_v <= 1'b0;
    end else if (stop_ev) begin
      if (pend_v) act_q <= pend_q;
      pend_v <= 1'b0;
    end else if (wr_stb) begin
      pend_q <= wr_data;
      pend_v <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_en_o  <= 1'b0;
      chan_sel_o <= 1'b0;
      irq_n_o    <= 1'b1;
    end else begin
      chan_en_o  <= act_q[2];
      chan_sel_o <= act_q[2] & act_q[0];
      irq_n_o    <= &irq_s;
    end
  end

  assign status_o = {2'b00, ~irq_s[1], ~irq_s[0], 1'b0, act_q};

  // R3
  apply_on_stop_chk: assert property (@(posedge clk) disable iff (rst)
    !stop_ev |=> $stable(act_q));

  // R8
  start_drops_chk: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> !pend_v);

  // R9
  irq_low_chk: assert property (@(posedge clk) disable iff (rst)
    !(&irq_s) |=> !irq_n_o);

  // R9
  irq_high_chk: assert property (@(posedge clk) disable iff (rst)
    (&irq_s) |=> irq_n_o);
endmodule

// File: rtl/i2c_chan_mux.sv
module i2c_chan_mux
  import mux_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic [1:0] irq_n_i,
  output logic       sda_pull_o,
  output logic       irq_n_o,
  output logic       chan_en_o,
  output logic       chan_sel_o
);
  logic                 scl_rise;
  logic                 scl_fall;
  logic                 sda_q;
  logic                 start_ev;
  logic                 stop_ev;
  logic                 wr_stb;
  logic [REG_BITS-1:0]  wr_data;
  logic [BYTE_BITS-1:0] status;

  i2c_line_sync #(.STAGES(STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_q    (sda_q),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  i2c_target_fsm #(.ADDR_HI(DEV_HI)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .sda_q      (sda_q),
    .start_ev   (start_ev),
    .stop_ev    (stop_ev),
    .strap_i    (strap_i),
    .tx_byte    (status),
    .sda_pull_o (sda_pull_o),
    .wr_stb     (wr_stb),
    .wr_data    (wr_data)
  );

  chan_reg #(.STAGES(STAGES)) u_reg (
    .clk        (clk),
    .rst        (rst),
    .wr_stb     (wr_stb),
    .wr_data    (wr_data),
    .start_ev   (start_ev),
    .stop_ev    (stop_ev),
    .irq_n_i    (irq_n_i),
    .chan_en_o  (chan_en_o),
    .chan_sel_o (chan_sel_o),
    .irq_n_o    (irq_n_o),
    .status_o   (status)
  );
endmodule

// File: tb/sim_i2c_chan_mux.sv
module sim_i2c_chan_mux;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic [1:0] irq_n = 2'b11;
  logic sda_pull, irq_n_o, chan_en, chan_sel;
  logic sda_bus;

  assign sda_bus = sda_m & ~sda_pull;
  always #5 clk = ~clk;

  i2c_chan_mux u0 (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl),
    .sda_i      (sda_bus),
    .strap_i    (strap),
    .irq_n_i    (irq_n),
    .sda_pull_o (sda_pull),
    .irq_n_o    (irq_n_o),
    .chan_en_o  (chan_en),
    .chan_sel_o (chan_sel)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int settle = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [2:0] m_act = 3'b000;
  logic [2:0] m_pend = 3'b000;
  bit m_pv = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference model compared on every clock once outputs have settled (R4, R9, R3 hold)
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (settle > 0) settle--;
      else begin
        chk("R4/R3 chan_en", {31'b0, chan_en}, {31'b0, m_act[2]});
        chk("R4/R3 chan_sel", {31'b0, chan_sel}, {31'b0, m_act[2] & m_act[0]});
        chk("R9 irq_n_o", {31'b0, irq_n_o}, {31'b0, &irq_n});
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qw();
    scl = 1'b1; qw();
    sda_m = 1'b0; m_pv = 1'b0; qw();
    scl = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw();
    scl = 1'b1; qw();
    sda_m = 1'b1;
    if (m_pv) m_act = m_pend;
    m_pv = 1'b0;
    settle = 8;
    qw();
  endtask

  task automatic wr_bit(input logic b);
    sda_m = b; qw();
    scl = 1'b1; qw(); qw();
    scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, output int lows);
    for (int i = 7; i >= 0; i--) wr_bit(d[i]);
    sda_m = 1'b1; qw();
    scl = 1'b1;
    lows = 0;
    repeat (2*Q) begin
      @(negedge clk);
      if (!sda_bus) lows++;
    end
    scl = 1'b0;
  endtask

  task automatic rd_byte(input bit mack, input logic [1:0] irq_next,
                         output logic [7:0] d, output int drv);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; qw();
      scl = 1'b1; qw();
      d[i] = sda_bus; qw();
      scl = 1'b0;
    end
    sda_m = ~mack;
    irq_n = irq_next;
    settle = 8;
    qw();
    scl = 1'b1;
    drv = 0;
    repeat (2*Q) begin
      @(negedge clk);
      if (sda_pull) drv++;
    end
    scl = 1'b0;
  endtask

  function automatic logic [7:0] adr(input logic [2:0] s, input logic rw);
    return {4'b1110, s, rw};
  endfunction

  function automatic logic [7:0] status_exp(input logic [1:0] irqv, input logic [2:0] r);
    return {2'b00, ~irqv[1], ~irqv[0], 1'b0, r};
  endfunction

  int lows;
  int drv;
  logic [7:0] rb;

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 chan_en after reset", {31'b0, chan_en}, 32'd0);
    chk("R10 chan_sel after reset", {31'b0, chan_sel}, 32'd0);
    chk("R10 sda_pull after reset", {31'b0, sda_pull}, 32'd0);

    // R1 R2 R3: write with upper bits set, held long before stop
    bus_start();
    send_byte(adr(3'b101, 1'b0), lows);
    chk("R1 address acknowledged", lows, 2*Q);
    send_byte(8'hFC, lows);
    chk("R2 data ack over full high", lows, 2*Q);
    m_pend = 3'b100; m_pv = 1'b1;
    repeat (60) @(negedge clk);
    bus_stop();
    repeat (12) @(negedge clk);
    chk("R3 applied at stop en", {31'b0, chan_en}, 32'd1);
    chk("R3 applied at stop sel", {31'b0, chan_sel}, 32'd0);

    // R5: read back, upper bits dropped
    bus_start();
    send_byte(adr(3'b101, 1'b1), lows);
    chk("R1 read address ack", lows, 2*Q);
    rd_byte(1'b0, irq_n, rb, drv);
    chk("R5 status byte", {24'b0, rb}, {24'b0, status_exp(irq_n, 3'b100)});
    chk("R6 no drive in host ack slot", drv, 0);
    bus_stop();

    // R4: bit 1 ignored by decode, stored for read
    bus_start();
    send_byte(adr(3'b101, 1'b0), lows);
    send_byte(8'h07, lows);
    m_pend = 3'b111; m_pv = 1'b1;
    bus_stop();
    repeat (12) @(negedge clk);
    chk("R4 value 111 selects channel 1", {30'b0, chan_en, chan_sel}, 32'd3);
    bus_start();
    send_byte(adr(3'b101, 1'b1), lows);
    rd_byte(1'b0, irq_n, rb, drv);
    chk("R4 bit 1 read back", {24'b0, rb}, {24'b0, status_exp(irq_n, 3'b111)});
    bus_stop();
    bus_start();
    send_byte(adr(3'b101, 1'b0), lows);
    send_byte(8'h03, lows);
    m_pend = 3'b011; m_pv = 1'b1;
    bus_stop();
    repeat (12) @(negedge clk);
    chk("R4 bit 2 clear disconnects", {30'b0, chan_en, chan_sel}, 32'd0);

    // R9 and R6: interrupts, repeated reads with live status, release after nack
    irq_n = 2'b10; settle = 8;
    repeat (12) @(negedge clk);
    chk("R9 one line low", {31'b0, irq_n_o}, 32'd0);
    bus_start();
    send_byte(adr(3'b101, 1'b1), lows);
    rd_byte(1'b1, 2'b01, rb, drv);
    chk("R5 first byte INT0", {24'b0, rb}, {24'b0, status_exp(2'b10, 3'b011)});
    rd_byte(1'b1, 2'b01, rb, drv);
    chk("R6 second byte live status", {24'b0, rb}, {24'b0, status_exp(2'b01, 3'b011)});
    rd_byte(1'b0, 2'b01, rb, drv);
    chk("R6 third byte", {24'b0, rb}, {24'b0, status_exp(2'b01, 3'b011)});
    lows = 0;
    for (int i = 0; i < 9; i++) begin
      sda_m = 1'b1; qw();
      scl = 1'b1;
      repeat (2*Q) begin
        @(negedge clk);
        if (sda_pull) lows++;
      end
      scl = 1'b0;
    end
    chk("R6 released after nack", lows, 0);
    bus_stop();
    irq_n = 2'b11; settle = 8;
    repeat (12) @(negedge clk);
    chk("R9 both lines high", {31'b0, irq_n_o}, 32'd1);

    // R1: wrong straps, wrong fixed part, then strap change
    bus_start();
    send_byte(adr(3'b001, 1'b0), lows);
    chk("R1 strap mismatch no ack", lows, 0);
    send_byte(8'h05, lows);
    chk("R1 rest of transaction ignored", lows, 0);
    bus_stop();
    bus_start();
    send_byte({4'b1100, 3'b101, 1'b0}, lows);
    chk("R1 fixed part mismatch no ack", lows, 0);
    bus_stop();
    strap = 3'b010;
    repeat (4) @(negedge clk);
    bus_start();
    send_byte(adr(3'b010, 1'b1), lows);
    chk("R1 new strap acknowledged", lows, 2*Q);
    rd_byte(1'b0, irq_n, rb, drv);
    chk("R1 ignored write left register", {24'b0, rb}, {24'b0, status_exp(irq_n, 3'b011)});
    bus_stop();

    // R7: several data bytes, last one wins
    bus_start();
    send_byte(adr(3'b010, 1'b0), lows);
    send_byte(8'h00, lows);
    chk("R7 byte 1 ack", lows, 2*Q);
    send_byte(8'h04, lows);
    chk("R7 byte 2 ack", lows, 2*Q);
    send_byte(8'hE5, lows);
    chk("R7 byte 3 ack", lows, 2*Q);
    m_pend = 3'b101; m_pv = 1'b1;
    bus_stop();
    repeat (12) @(negedge clk);
    chk("R7 last byte applied", {30'b0, chan_en, chan_sel}, 32'd3);

    // R8: start inside a byte aborts the pending write
    bus_start();
    send_byte(adr(3'b010, 1'b0), lows);
    send_byte(8'h04, lows);
    m_pend = 3'b100; m_pv = 1'b1;
    wr_bit(1'b0); wr_bit(1'b0); wr_bit(1'b1);
    bus_start();
    send_byte(adr(3'b010, 1'b1), lows);
    chk("R8 address matching after restart", lows, 2*Q);
    rd_byte(1'b0, irq_n, rb, drv);
    chk("R8 pending write discarded", {24'b0, rb}, {24'b0, status_exp(irq_n, 3'b101)});
    bus_stop();
    repeat (12) @(negedge clk);
    chk("R8 outputs unchanged", {30'b0, chan_en, chan_sel}, 32'd3);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule